// File: doc/BRIEF.md
# Instrument Bus Master Interface

This block lets a processor run transfers on a parallel instrument bus through a two-register port. The bus has eight address lines, eight data lines, an active-low data-valid strobe, a service-request input from the instrument modules and a poll output. The processor loads a data byte and then writes an address byte, and that second write starts the transfer. Bit 7 of the address byte sets the direction. With it clear, the byte in the data register goes out to the instrument. With it set, a byte is read back and kept in a result register.

Every transfer has two phases. First comes a setup phase of a parameterised number of clocks, during which address (and write data) are driven while the strobe stays high. Then the strobe goes low for a fixed number of clocks. A service request from the instrument side starts a poll cycle. In that cycle the poll line is raised together with the strobe, the requester places its identity on the data lines, the identity is captured, and an interrupt is raised. A request that arrives while a transfer is running is held and served afterwards. Driving the external-control input low, or the test-disable input high, releases every bus output at once and holds the block idle.

Top module: `ib_master`

## Requirements
- R1: After reset the strobe `ib_dv_n` is 1, `ib_poll` is 0, both output enables are 0, `busy` and `irq` are 0, and `rd_data` is 0x00.
- R2: Suppose the address register (`cpu_sel`=1) is written with bit 7 = 0 while the block is idle. From the next cycle the block drives that address and the last data-register byte (`cpu_sel`=0) with both enables high. `ib_dv_n` then falls after exactly DV_DELAY cycles of this setup.
- R3: An address write with bit 7 = 1 starts a read. The address is driven, `ib_dout_oe` stays 0, and `rd_data` takes the value of `ib_din` from the last clock that the strobe is low.
- R4: Each transfer holds `ib_dv_n` low for exactly DV_HOLD (default 4) consecutive clocks.
- R5: `busy` is 1 for DV_DELAY+DV_HOLD cycles, starting in the cycle after the start write. Any register write made while `busy` is 1 is ignored: it starts no transfer and leaves the data register unchanged.
- R6: When `srq` is high while the block is idle, a poll cycle runs. `ib_poll` is high exactly while `ib_dv_n` is low, and neither output enable is asserted. The requester's byte on `ib_din` is stored in `rd_data` and `irq` is set. A pending request wins over a processor write in the same cycle.
- R7: An `srq` that arrives during a transfer is held, and its poll cycle follows once that transfer finishes.
- R8: `irq` is set only by a completed poll. It is cleared by any accepted register write. Reads leave it unchanged.
- R9: While `ext_ctl_n` is 0 or `test_dis` is 1, `ib_bus_en` is 0, both enables are 0, `ib_dv_n` is 1 and `ib_poll` is 0, all in the same cycle. Any transfer in progress is dropped. Register writes and service requests made during that time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 1 | 0 = data register, 1 = address register (starts transfer) |
| cpu_wdata | input | 8 | Register write data |
| srq | input | 1 | Service request from instrument side, active high |
| ext_ctl_n | input | 1 | External control, low releases the bus |
| test_dis | input | 1 | Test disable, high releases the bus |
| ib_din | input | 8 | Instrument data lines, inbound |
| ib_addr | output | 8 | Instrument address lines |
| ib_addr_oe | output | 1 | Address buffer enable |
| ib_dout | output | 8 | Instrument data lines, outbound |
| ib_dout_oe | output | 1 | Data buffer enable |
| ib_dv_n | output | 1 | Data valid strobe, active low |
| ib_poll | output | 1 | Poll line |
| ib_bus_en | output | 1 | Bus enable, 0 while released |
| busy | output | 1 | Transfer in progress |
| rd_data | output | 8 | Last read or poll byte |
| irq | output | 1 | Poll-complete interrupt |

## Verification
The bench counts the setup and strobe cycles of every transfer. An off-by-one in the delay counter would show up as a strobe of three or five clocks, or as a setup that is one clock short. It fires register writes into a busy transfer: a block that failed to ignore them would produce a strobe nobody expected, or would corrupt the data byte sent by a later address-only write. It raises a service request in the middle of a write. A block without a pending latch would drop the poll, and a block that serviced the request too early would reorder the strobes. It releases the bus during setup and requests service while the bus is released; a design that kept the request or the transfer would run a phantom strobe after the release ends.

// File: rtl/ib_master_pkg.sv
// Shared widths, sequencer states and the transfer command record.
package ib_master_pkg;
    localparam int IB_AW = 8;
    localparam int IB_DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             is_poll;
        logic             is_read;
        logic [IB_AW-1:0] addr;
        logic [IB_DW-1:0] wdata;
    } ib_cmd_t;
endpackage

// File: rtl/ib_cpu_regs.sv
// Processor register port: holds the outbound data byte and turns an
// address-register write into a transfer request.
// Assumes: writes are single-cycle pulses; busy and bus_en come from the
// sequencer and top; a poll start in the same cycle wins over the processor.
module ib_cpu_regs
    import ib_master_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic             cpu_sel,
    input  logic [IB_DW-1:0] cpu_wdata,
    input  logic             busy,
    input  logic             bus_en,
    input  logic             start_poll,
    output logic             start_xfer,
    output ib_cmd_t          cmd,
    output logic             irq_clr
);
    logic             accept;
    logic [IB_DW-1:0] data_q;

    // Accept a write only when idle and the bus is enabled.
    assign accept     = cpu_we && !busy && bus_en;
    assign start_xfer = accept && cpu_sel && !start_poll;
    assign irq_clr    = accept;

    // Data register load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (accept && !cpu_sel)
            data_q <= cpu_wdata;
    end

    // Command formed from the address byte being written.
    always_comb begin
        cmd.is_poll = 1'b0;
        cmd.is_read = cpu_wdata[IB_AW-1];
        cmd.addr    = cpu_wdata;
        cmd.wdata   = data_q;
    end

    // Writes during a transfer must leave the data byte alone.
    p_busy_keeps_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_we && !cpu_sel) |=> $stable(data_q));
endmodule

// File: rtl/ib_srq_arb.sv
// Service-request arbiter: latches requests that arrive while busy and
// issues a poll start in the first idle cycle with the bus enabled.
// Assumes: srq is synchronous to clk; releasing the bus discards requests.
module ib_srq_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic srq,
    input  logic bus_en,
    input  logic idle,
    output logic start_poll
);
    logic pend_q;

    assign start_poll = idle && bus_en && (srq || pend_q);

    // Pending-request latch.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_en)
            pend_q <= 1'b0;
        else if (start_poll)
            pend_q <= 1'b0;
        else if (srq)
            pend_q <= 1'b1;
    end

    // A request not served at once must be remembered.
    p_request_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && bus_en && !start_poll) |=> (pend_q || !bus_en));
endmodule

// File: rtl/ib_seq.sv
// Transfer sequencer: setup phase of DV_DELAY clocks, strobe phase of
// DV_HOLD clocks, read/poll capture on the last strobe clock, poll interrupt.
// Assumes: DV_DELAY >= 1, DV_HOLD >= 1; starts are only offered while idle.
module ib_seq
    import ib_master_pkg::*;
#(
    parameter int DV_DELAY = 2,
    parameter int DV_HOLD  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             start_xfer,
    input  ib_cmd_t          cpu_cmd,
    input  logic             start_poll,
    input  logic [IB_DW-1:0] ib_din,
    input  logic             irq_clr,
    output seq_state_e       state,
    output ib_cmd_t          cur,
    output logic [IB_DW-1:0] rd_data,
    output logic             irq,
    output logic             idle
);
    localparam int CMAX = (DV_DELAY > DV_HOLD) ? DV_DELAY : DV_HOLD;
    localparam int CW   = $clog2(CMAX + 1);

    logic [CW-1:0] cnt;
    logic          last_strobe;
    logic          poll_done;

    assign idle        = (state == ST_IDLE);
    assign last_strobe = bus_en && (state == ST_STROBE) && (cnt == CW'(DV_HOLD - 1));
    assign poll_done   = last_strobe && cur.is_poll;

    // Phase state machine and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cur   <= '0;
        end else if (!bus_en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_poll) begin
                        cur   <= '{is_poll: 1'b1, is_read: 1'b1, addr: '0, wdata: '0};
                        state <= ST_SETUP;
                    end else if (start_xfer) begin
                        cur   <= cpu_cmd;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt == CW'(DV_DELAY - 1)) begin
                        cnt   <= '0;
                        state <= ST_STROBE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (cnt == CW'(DV_HOLD - 1)) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Capture of inbound byte at the end of a read or poll.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (last_strobe && cur.is_read)
            rd_data <= ib_din;
    end

    // Poll-complete interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (poll_done)
            irq <= 1'b1;
        else if (irq_clr)
            irq <= 1'b0;
    end

    // Releasing the bus returns the sequencer to idle.
    p_release_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> (state == ST_IDLE));
endmodule

// File: rtl/ib_pin_drv.sv
// Pin driver: derives address/data enables, strobe and poll from the
// sequencer phase, and forces every output inactive when the bus is released.
// Assumes: bus_en may change in any cycle; release takes effect combinationally.
module ib_pin_drv
    import ib_master_pkg::*;
(
    input  seq_state_e       state,
    input  ib_cmd_t          cur,
    input  logic             bus_en,
    output logic [IB_AW-1:0] ib_addr,
    output logic             ib_addr_oe,
    output logic [IB_DW-1:0] ib_dout,
    output logic             ib_dout_oe,
    output logic             ib_dv_n,
    output logic             ib_poll
);
    logic active;
    logic strobe;

    // Output gating by phase and bus enable.
    always_comb begin
        active     = bus_en && (state != ST_IDLE);
        strobe     = bus_en && (state == ST_STROBE);
        ib_addr_oe = active && !cur.is_poll;
        ib_dout_oe = active && !cur.is_poll && !cur.is_read;
        ib_addr    = ib_addr_oe ? cur.addr  : '0;
        ib_dout    = ib_dout_oe ? cur.wdata : '0;
        ib_dv_n    = !strobe;
        ib_poll    = strobe && cur.is_poll;
    end
endmodule

// File: rtl/ib_master.sv
// Instrument bus master top: register port, service-request arbiter,
// transfer sequencer and pin driver.
// Assumes: all inputs synchronous to clk; tri-state buffers outside use the
// enable outputs.
module ib_master #(
    parameter int DV_DELAY = 2,
    parameter int DV_HOLD  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_we,
    input  logic       cpu_sel,
    input  logic [7:0] cpu_wdata,
    input  logic       srq,
    input  logic       ext_ctl_n,
    input  logic       test_dis,
    input  logic [7:0] ib_din,
    output logic [7:0] ib_addr,
    output logic       ib_addr_oe,
    output logic [7:0] ib_dout,
    output logic       ib_dout_oe,
    output logic       ib_dv_n,
    output logic       ib_poll,
    output logic       ib_bus_en,
    output logic       busy,
    output logic [7:0] rd_data,
    output logic       irq
);
    import ib_master_pkg::*;

    logic       bus_en;
    logic       idle;
    logic       start_xfer;
    logic       start_poll;
    logic       irq_clr;
    ib_cmd_t    cpu_cmd;
    ib_cmd_t    cur;
    seq_state_e state;

    assign bus_en    = ext_ctl_n && !test_dis;
    assign ib_bus_en = bus_en;
    assign busy      = !idle;

    ib_cpu_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .busy(busy), .bus_en(bus_en),
        .start_poll(start_poll), .start_xfer(start_xfer), .cmd(cpu_cmd),
        .irq_clr(irq_clr)
    );

    ib_srq_arb u_arb (
        .clk(clk), .rst_n(rst_n), .srq(srq), .bus_en(bus_en), .idle(idle),
        .start_poll(start_poll)
    );

    ib_seq #(.DV_DELAY(DV_DELAY), .DV_HOLD(DV_HOLD)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .start_xfer(start_xfer),
        .cpu_cmd(cpu_cmd), .start_poll(start_poll), .ib_din(ib_din),
        .irq_clr(irq_clr), .state(state), .cur(cur), .rd_data(rd_data),
        .irq(irq), .idle(idle)
    );

    ib_pin_drv u_drv (
        .state(state), .cur(cur), .bus_en(bus_en), .ib_addr(ib_addr),
        .ib_addr_oe(ib_addr_oe), .ib_dout(ib_dout), .ib_dout_oe(ib_dout_oe),
        .ib_dv_n(ib_dv_n), .ib_poll(ib_poll)
    );

    // Run length of the low strobe, for the width check.
    logic [7:0] dv_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            dv_low_run <= '0;
        else if (!ib_dv_n)
            dv_low_run <= (dv_low_run == 8'hFF) ? dv_low_run : dv_low_run + 1'b1;
        else
            dv_low_run <= '0;
    end

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ib_dv_n) && bus_en && $past(bus_en)) |-> (dv_low_run == 8'(DV_HOLD)));

    p_setup_before_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ib_dv_n) && ib_addr_oe) |-> $past(ib_addr_oe));

    p_read_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_addr_oe && ib_addr[7]) |-> !ib_dout_oe);

    p_poll_with_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ib_poll |-> (!ib_dv_n && !ib_addr_oe && !ib_dout_oe));

    p_irq_from_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ib_poll));
endmodule

// File: tb/tb_ib_master.sv
module tb_ib_master;
    localparam int DVD  = 2;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic       cpu_sel = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       srq = 1'b0;
    logic       ext_ctl_n = 1'b1;
    logic       test_dis = 1'b0;
    logic [7:0] ib_din;
    logic [7:0] ib_addr, ib_dout, rd_data;
    logic       ib_addr_oe, ib_dout_oe, ib_dv_n, ib_poll, ib_bus_en, busy, irq;

    logic [7:0] resp_val = 8'h00;
    logic [7:0] poll_id  = 8'h00;
    assign ib_din = ib_poll ? poll_id : resp_val;

    always #10 clk = ~clk;

    ib_master #(.DV_DELAY(DVD), .DV_HOLD(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .srq(srq), .ext_ctl_n(ext_ctl_n),
        .test_dis(test_dis), .ib_din(ib_din), .ib_addr(ib_addr),
        .ib_addr_oe(ib_addr_oe), .ib_dout(ib_dout), .ib_dout_oe(ib_dout_oe),
        .ib_dv_n(ib_dv_n), .ib_poll(ib_poll), .ib_bus_en(ib_bus_en),
        .busy(busy), .rd_data(rd_data), .irq(irq)
    );

    typedef struct {
        bit         poll;
        bit         rd;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] resp;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per strobe and compares.
    bit   prev_dv = 1'b1;
    bit   have = 1'b0;
    int   setup_len = 0;
    int   low_len = 0;
    exp_t cur_e;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy) setup_len = 0;
            else if (ib_dv_n) setup_len++;
            if (ib_poll && ib_dv_n)
                chk(1'b0, "R6", "poll outside strobe", 1, 0);
            if (!ib_dv_n && prev_dv) begin
                low_len = 1;
                if (q.size() == 0) begin
                    have = 1'b0;
                    chk(1'b0, "R5", "unexpected strobe", 1, 0);
                end else begin
                    have  = 1'b1;
                    cur_e = q.pop_front();
                    chk(setup_len == DVD, "R2", "setup cycles", setup_len, DVD);
                    if (cur_e.poll) begin
                        chk(ib_poll && !ib_addr_oe && !ib_dout_oe, "R6", "poll pins",
                            {ib_poll, ib_addr_oe, ib_dout_oe}, 3'b100);
                    end else begin
                        chk(ib_addr_oe && ib_addr == cur_e.addr && !ib_poll, "R2", "address",
                            ib_addr, cur_e.addr);
                        if (cur_e.rd)
                            chk(!ib_dout_oe, "R3", "read drives data", ib_dout_oe, 0);
                        else
                            chk(ib_dout_oe && ib_dout == cur_e.data, "R2", "write data",
                                ib_dout, cur_e.data);
                    end
                end
            end else if (!ib_dv_n) begin
                low_len++;
            end
            if (ib_dv_n && !prev_dv && have) begin
                chk(low_len == HOLD, "R4", "strobe width", low_len, HOLD);
                if (cur_e.rd)
                    chk(rd_data == cur_e.resp, cur_e.poll ? "R6" : "R3", "captured byte",
                        rd_data, cur_e.resp);
                if (cur_e.poll)
                    chk(irq == 1'b1, "R6", "irq after poll", irq, 1);
                have = 1'b0;
            end
            prev_dv = ib_dv_n;
        end
    end

    task automatic cpu_write(input bit sel, input logic [7:0] v);
        @(posedge clk); #2;
        cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = v;
        @(posedge clk); #2;
        cpu_we = 1'b0;
    endtask

    task automatic pulse_srq();
        @(posedge clk); #2; srq = 1'b1;
        @(posedge clk); #2; srq = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || q.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        q.push_back('{poll: 1'b0, rd: 1'b0, addr: a & 8'h7F, data: d, resp: 8'h00});
        cpu_write(1'b0, d);
        cpu_write(1'b1, a & 8'h7F);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] r);
        resp_val = r;
        q.push_back('{poll: 1'b0, rd: 1'b1, addr: a | 8'h80, data: 8'h00, resp: r});
        cpu_write(1'b1, a | 8'h80);
    endtask

    task automatic do_poll(input logic [7:0] id);
        poll_id = id;
        q.push_back('{poll: 1'b1, rd: 1'b1, addr: 8'h00, data: 8'h00, resp: id});
        pulse_srq();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ib_dv_n && !ib_poll && !ib_addr_oe && !ib_dout_oe, "R1", "bus idle pins",
            {ib_dv_n, ib_poll, ib_addr_oe, ib_dout_oe}, 4'b1000);
        chk(!busy && !irq && rd_data == 8'h00, "R1", "busy/irq/rd_data",
            {busy, irq, rd_data}, 0);

        // R2/R5: write plus busy duration
        do_write(8'h12, 8'hA5);
        n = 0;
        forever begin
            @(negedge clk);
            if (busy) n++; else break;
        end
        chk(n == DVD + HOLD, "R5", "busy length", n, DVD + HOLD);
        wait_idle();
        do_write(8'h7F, 8'h00); wait_idle();
        do_write(8'h00, 8'hFF); wait_idle();

        // R3: reads; R8: reads leave irq clear
        do_read(8'h05, 8'h3C); wait_idle();
        chk(irq == 1'b0, "R8", "irq after read", irq, 0);
        do_read(8'hFF, 8'hC3); wait_idle();

        // R6: poll from idle; R8: cleared by write
        do_poll(8'h5A); wait_idle();
        chk(irq == 1'b1, "R8", "irq held", irq, 1);
        cpu_write(1'b0, 8'h11);
        @(negedge clk);
        chk(irq == 1'b0, "R8", "irq cleared by write", irq, 0);

        // R5: writes while busy are ignored
        do_write(8'h34, 8'hA5);
        cpu_write(1'b0, 8'h3C);
        cpu_write(1'b1, 8'h55);
        wait_idle();
        q.push_back('{poll: 1'b0, rd: 1'b0, addr: 8'h21, data: 8'hA5, resp: 8'h00});
        cpu_write(1'b1, 8'h21);
        wait_idle();

        // R7: request during a write is served afterwards
        do_write(8'h40, 8'h99);
        poll_id = 8'h66;
        q.push_back('{poll: 1'b1, rd: 1'b1, addr: 8'h00, data: 8'h00, resp: 8'h66});
        pulse_srq();
        wait_idle();
        chk(rd_data == 8'h66, "R7", "pending poll id", rd_data, 8'h66);

        // R9: external control releases the bus mid-setup
        cpu_write(1'b0, 8'h77);
        cpu_write(1'b1, 8'h10);
        ext_ctl_n = 1'b0;
        @(negedge clk);
        chk(!ib_bus_en && !ib_addr_oe && !ib_dout_oe && ib_dv_n && !ib_poll, "R9",
            "released pins", {ib_bus_en, ib_addr_oe, ib_dout_oe, ib_dv_n, ib_poll}, 5'b00010);
        @(negedge clk);
        chk(!busy, "R9", "transfer dropped", busy, 0);
        pulse_srq();
        cpu_write(1'b1, 8'h20);
        repeat (3) @(negedge clk);
        @(posedge clk); #2 ext_ctl_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(!busy && ib_dv_n, "R9", "no activity after release", busy, 0);

        // R9: test disable
        @(posedge clk); #2 test_dis = 1'b1;
        @(negedge clk);
        chk(!ib_bus_en && ib_dv_n && !ib_poll, "R9", "test disable", ib_bus_en, 0);
        pulse_srq();
        repeat (2) @(negedge clk);
        @(posedge clk); #2 test_dis = 1'b0;
        repeat (12) @(negedge clk);
        chk(!busy, "R9", "request dropped while disabled", busy, 0);

        do_write(8'h5A, 8'h77); wait_idle();
        chk(q.size() == 0, "R2", "all transfers seen", q.size(), 0);
        finish_run();
    end
endmodule